// File: doc/BRIEF.md
# Configurable stereo serial audio port

The block is a master-mode stereo PCM port. From the master clock it derives a bit clock and a left/right word clock. It shifts a pair of transmit samples out on a serial data line. It also assembles the samples arriving on a serial input into a left and a right word. One 8-bit configuration register controls the port:

- the master-clock ratio, which sets the bit-clock divide;
- the framing family (justified or I2S);
- the data placement inside each channel slot;
- a clock-park mode;
- gating of a buffered copy of the master clock.

The register can be written only while the system reset input is low. Software therefore programs it during the reset phase and then releases reset to start framing. A read returns the stored value at any time.

Each channel slot is 32 bit clocks long, so one frame is 64 bit clocks. A sample word is 24 bits wide and MSB-aligned. The 20-bit and 16-bit formats carry the upper 20 or 16 bits of the word. Transmit data changes on the bit-clock falling edge. Receive data is sampled on the rising edge.

Top module: `sap_port`

## Requirements
- R1: The register takes `cmd_wdata` on a clock edge with `cmd_valid` high and `cmd_code` = 60h only while `rst_sys_n` is low. A write while `rst_sys_n` is high, or a write with any other code, leaves the stored value unchanged.
- R2: After `por_n` the register holds 00h. With `cmd_valid` high and `cmd_code` = 70h, `rd_data` shows the stored value, and bit 0 always reads 0. Otherwise `rd_data` is 00h.
- R3: Bits 7:6 set the bit-clock period in master clocks. Code 01 gives 6. Codes 00, 10 and 11 give 8. The bit clock is low for the first half of each period.
- R4: The word clock changes only on a bit-clock falling edge, every 32 bit clocks. The left slot starts at the first falling edge after `rst_sys_n` rises. The left slot has the word clock high when bit 5 is 0 and low when bit 5 is 1.
- R5: With bit 5 at 0, bits 4:3 place the sample in a slot of positions 0..31, counted from the word-clock edge. Code 00 sends 24 bits starting at position 0. Codes 01, 10 and 11 send 24, 20 or 16 bits, MSB first, so that the last bit lands at position 31. All other positions are driven 0.
- R6: With bit 5 at 1, the port uses I2S placement whatever bits 4:3 hold: 24 bits, MSB first, starting at position 1.
- R7: The receiver captures `sdin` at the positions that R5/R6 assign to data. It ignores all other positions, and the unreceived low bits of a short format read 0. `rx_left` or `rx_right` updates at the end of its slot. `rx_valid` pulses for one clock after each right slot.
- R8: With bit 2 at 1 and `rst_sys_n` high, the following hold:
  - `bclk` stays low;
  - `lrclk` stays high (bit 5 = 0) or low (bit 5 = 1);
  - `sdout` stays low;
  - `sdin` is ignored and the receive outputs keep their values.
- R9: With bit 1 at 0, `clk_out` follows `clk`. With bit 1 at 1, `clk_out` is low. A change applies from the first `clk` high phase after the writing edge.
- R10: While `rst_sys_n` is low, `bclk` and `sdout` are low and framing is halted.
- R11: `tx_left` and `tx_right` are sampled at the start of every frame, at the falling edge that opens the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-on reset, active low, clears the register |
| rst_sys_n | input | 1 | System reset, active low; opens the register for writing |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code: 60h write, 70h read |
| cmd_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| tx_left | input | 24 | Left transmit sample |
| tx_right | input | 24 | Right transmit sample |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | Pulse after a right sample is stored |
| clk_out | output | 1 | Gated copy of the master clock |

## Verification
The bench sweeps every ratio code from 00 to 10 against both families and all four placement codes. In each of these 24 configurations it acts as the far-end device:

- it times every bit-clock period;
- it checks each slot length and the word-clock level of the left slot;
- it compares every `sdout` bit with the placement it derives itself from the configuration.

During the same run it drives `sdin` with a known word at the data positions and with ones everywhere else. The received words therefore show both the placement and the masking of ignored bits. Because the I2S configurations use every placement code, any leak of bits 4:3 into I2S placement is exposed.

Separate cases cover the following:

- register locking and the bit-0 mask;
- clock parking in both families;
- halting while in reset;
- both states of the gated master clock.

// File: rtl/sap_pkg.sv
package sap_pkg;
   localparam logic [7:0] CMD_WR = 8'h60;
   localparam logic [7:0] CMD_RD = 8'h70;

   typedef struct packed {
      logic [1:0] ratio;
      logic       i2s;
      logic [1:0] place;
      logic       park;
      logic       cko_off;
   } sap_cfg_t;

   // first slot position that carries sample data
   function automatic int lead_bits(input logic i2s, input logic [1:0] place,
                                    input int slot, input int sw);
      if (i2s) return 1;
      case (place)
         2'b00:   return 0;
         2'b01:   return slot - sw;
         2'b10:   return slot - (sw - 4);
         default: return slot - (sw - 8);
      endcase
   endfunction

   // number of sample bits carried in a slot
   function automatic int data_bits(input logic i2s, input logic [1:0] place,
                                    input int sw);
      if (i2s || !place[1]) return sw;
      if (!place[0]) return sw - 4;
      return sw - 8;
   endfunction
endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
   import sap_pkg::*;
#(
   parameter bit RETIME_CKO = 1'b1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_sys_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   input  logic [7:0] cmd_wdata,
   output logic [7:0] rd_data,
   output sap_cfg_t   cfg,
   output logic       clk_out
);
   logic [7:0] reg_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         reg_q <= 8'h00;
      else if (cmd_valid && cmd_code == CMD_WR && !rst_sys_n)
         reg_q <= cmd_wdata & 8'hFE;
   end

   assign rd_data = (cmd_valid && cmd_code == CMD_RD) ? reg_q : 8'h00;
   assign cfg     = sap_cfg_t'(reg_q[7:1]);

   generate
      if (RETIME_CKO) begin : g_cko_retimed
         logic gate_q;
         always_ff @(negedge clk or negedge por_n) begin
            if (!por_n) gate_q <= 1'b0;
            else        gate_q <= reg_q[1];
         end
         assign clk_out = clk & ~gate_q;
      end else begin : g_cko_direct
         assign clk_out = clk & ~reg_q[1];
      end
   endgenerate

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
      rst_sys_n |=> $stable(reg_q)); // R1
   AST_RD_BIT0_LOW: assert property (@(posedge clk) disable iff (!por_n)
      cmd_valid && cmd_code == CMD_RD |-> !rd_data[0]); // R2
endmodule

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
   parameter  int SLOT_W  = 32,
   parameter  int DIV_STD = 8,
   parameter  int DIV_ALT = 6,
   localparam int CW      = $clog2(2 * SLOT_W),
   localparam int DW      = $clog2(DIV_STD > DIV_ALT ? DIV_STD : DIV_ALT) + 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          rst_sys_n,
   input  logic [1:0]    ratio,
   input  logic          i2s,
   input  logic          park,
   output logic          bclk,
   output logic          lrclk,
   output logic [CW-1:0] cnt,
   output logic          run,
   output logic          fall_stb,
   output logic          rise_stb
);
   logic [DW-1:0] div, dcnt;

   assign div      = (ratio == 2'b01) ? DW'(DIV_ALT) : DW'(DIV_STD);
   assign run      = rst_sys_n & ~park;
   assign fall_stb = run && (dcnt == div - 1'b1);
   assign rise_stb = run && (dcnt == (div >> 1) - 1'b1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         dcnt <= '0;
         bclk <= 1'b0;
         cnt  <= '1;
      end else if (!run) begin
         dcnt <= '0;
         bclk <= 1'b0;
         cnt  <= '1;
      end else if (fall_stb) begin
         dcnt <= '0;
         bclk <= 1'b0;
         cnt  <= cnt + 1'b1;
      end else begin
         dcnt <= dcnt + 1'b1;
         if (rise_stb) bclk <= 1'b1;
      end
   end

   // left slot is the lower half of the frame count
   assign lrclk = park ? ~i2s : (cnt[CW-1] ^ ~i2s);

   AST_PARK_BCLK_LOW: assert property (@(posedge clk) disable iff (!por_n)
      park |=> !bclk); // R8
   AST_HALT_BCLK_LOW: assert property (@(posedge clk) disable iff (!por_n)
      !rst_sys_n |=> !bclk); // R10
   AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!por_n)
      run && $past(run) && !$stable(lrclk) |-> $fell(bclk)); // R4
endmodule

// File: rtl/sap_tx.sv
module sap_tx
   import sap_pkg::*;
#(
   parameter  int SLOT_W   = 32,
   parameter  int SAMPLE_W = 24,
   localparam int CW       = $clog2(2 * SLOT_W),
   localparam int PW       = CW - 1,
   localparam int IW       = $clog2(SAMPLE_W)
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                run,
   input  logic                park,
   input  logic                fall_stb,
   input  logic [CW-1:0]       cnt,
   input  logic                i2s,
   input  logic [1:0]          place,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   output logic                sdout
);
   logic [SAMPLE_W-1:0] hold_l, hold_r, word;
   logic [CW-1:0]       nxt;
   logic [IW-1:0]       idx;
   logic                bit_nxt;
   int                  pos, k;

   always_comb begin
      nxt  = cnt + 1'b1;
      pos  = int'(nxt[PW-1:0]);
      k    = pos - lead_bits(i2s, place, SLOT_W, SAMPLE_W);
      idx  = IW'(SAMPLE_W - 1 - k);
      word = (nxt == '0) ? tx_left : (nxt[CW-1] ? hold_r : hold_l);
      bit_nxt = (k >= 0 && k < data_bits(i2s, place, SAMPLE_W)) ? word[idx] : 1'b0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sdout  <= 1'b0;
         hold_l <= '0;
         hold_r <= '0;
      end else if (!run) begin
         sdout <= 1'b0;
      end else if (fall_stb) begin
         sdout <= bit_nxt;
         if (nxt == '0) begin
            hold_l <= tx_left;
            hold_r <= tx_right;
         end
      end
   end

   AST_TX_PARK_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      park |=> !sdout); // R8
   AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!por_n)
      run && $past(run) && !$stable(sdout) |-> $past(fall_stb)); // R5
endmodule

// File: rtl/sap_rx.sv
module sap_rx
   import sap_pkg::*;
#(
   parameter  int SLOT_W   = 32,
   parameter  int SAMPLE_W = 24,
   localparam int CW       = $clog2(2 * SLOT_W),
   localparam int PW       = CW - 1,
   localparam int IW       = $clog2(SAMPLE_W)
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                run,
   input  logic                park,
   input  logic                rise_stb,
   input  logic [CW-1:0]       cnt,
   input  logic                i2s,
   input  logic [1:0]          place,
   input  logic                sdin,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                rx_valid
);
   logic [SAMPLE_W-1:0] shreg, nxt_sh;
   logic [IW-1:0]       idx;
   logic                slot_end;
   int                  pos, k;

   always_comb begin
      pos    = int'(cnt[PW-1:0]);
      k      = pos - lead_bits(i2s, place, SLOT_W, SAMPLE_W);
      idx    = IW'(SAMPLE_W - 1 - k);
      nxt_sh = shreg;
      if (k >= 0 && k < data_bits(i2s, place, SAMPLE_W)) nxt_sh[idx] = sdin;
      slot_end = (pos == SLOT_W - 1);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         shreg    <= '0;
         rx_left  <= '0;
         rx_right <= '0;
         rx_valid <= 1'b0;
      end else if (!run) begin
         shreg    <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rise_stb) begin
            if (slot_end) begin
               shreg <= '0;
               if (cnt[CW-1]) begin
                  rx_right <= nxt_sh;
                  rx_valid <= 1'b1;
               end else begin
                  rx_left <= nxt_sh;
               end
            end else begin
               shreg <= nxt_sh;
            end
         end
      end
   end

   AST_RX_PARK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      park |=> $stable(rx_left) && $stable(rx_right)); // R8
   AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!por_n)
      rx_valid |=> !rx_valid); // R7
endmodule

// File: rtl/sap_port.sv
module sap_port
   import sap_pkg::*;
#(
   parameter int SAMPLE_W   = 24,
   parameter int SLOT_W     = 32,
   parameter int DIV_STD    = 8,
   parameter int DIV_ALT    = 6,
   parameter bit RETIME_CKO = 1'b1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                rst_sys_n,
   input  logic                cmd_valid,
   input  logic [7:0]          cmd_code,
   input  logic [7:0]          cmd_wdata,
   output logic [7:0]          rd_data,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   input  logic                sdin,
   output logic                sdout,
   output logic                bclk,
   output logic                lrclk,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                rx_valid,
   output logic                clk_out
);
   localparam int CW = $clog2(2 * SLOT_W);

   generate
      if ((SLOT_W & (SLOT_W - 1)) != 0 || SLOT_W < 16)
         begin : g_bad_slot $error("SLOT_W must be a power of two, at least 16"); end
      if (SAMPLE_W < 12 || SAMPLE_W + 1 > SLOT_W)
         begin : g_bad_sample $error("SAMPLE_W must be 12..SLOT_W-1"); end
      if (DIV_STD < 2 || DIV_ALT < 2 || (DIV_STD % 2) != 0 || (DIV_ALT % 2) != 0)
         begin : g_bad_div $error("bit clock divides must be even and at least 2"); end
   endgenerate

   sap_cfg_t      cfg;
   logic [CW-1:0] cnt;
   logic          run, fall_stb, rise_stb;

   sap_ctrl #(.RETIME_CKO(RETIME_CKO)) u_ctrl (
      .clk(clk), .por_n(por_n), .rst_sys_n(rst_sys_n), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
      .cfg(cfg), .clk_out(clk_out));

   sap_clkgen #(.SLOT_W(SLOT_W), .DIV_STD(DIV_STD), .DIV_ALT(DIV_ALT)) u_clkgen (
      .clk(clk), .por_n(por_n), .rst_sys_n(rst_sys_n), .ratio(cfg.ratio),
      .i2s(cfg.i2s), .park(cfg.park), .bclk(bclk), .lrclk(lrclk), .cnt(cnt),
      .run(run), .fall_stb(fall_stb), .rise_stb(rise_stb));

   sap_tx #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_tx (
      .clk(clk), .por_n(por_n), .run(run), .park(cfg.park), .fall_stb(fall_stb),
      .cnt(cnt), .i2s(cfg.i2s), .place(cfg.place), .tx_left(tx_left),
      .tx_right(tx_right), .sdout(sdout));

   sap_rx #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)) u_rx (
      .clk(clk), .por_n(por_n), .run(run), .park(cfg.park), .rise_stb(rise_stb),
      .cnt(cnt), .i2s(cfg.i2s), .place(cfg.place), .sdin(sdin),
      .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

   AST_HALT_SDOUT_LOW: assert property (@(posedge clk) disable iff (!por_n)
      !rst_sys_n |=> !sdout); // R10
endmodule

// File: tb/sap_port_tb.sv
module sap_port_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_sys_n = 1'b0, cmd_valid = 1'b0, sdin = 1'b0;
   logic [7:0]  cmd_code = 8'h00, cmd_wdata = 8'h00;
   logic [23:0] tx_left = '0, tx_right = '0;
   logic [7:0]  rd_data;
   logic [23:0] rx_left, rx_right;
   logic        sdout, bclk, lrclk, rx_valid, clk_out;
   int          checks = 0, failures = 0;

   always #4 clk = ~clk;

   sap_port u_dut (
      .clk(clk), .por_n(por_n), .rst_sys_n(rst_sys_n), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
      .tx_left(tx_left), .tx_right(tx_right), .sdin(sdin), .sdout(sdout),
      .bclk(bclk), .lrclk(lrclk), .rx_left(rx_left), .rx_right(rx_right),
      .rx_valid(rx_valid), .clk_out(clk_out));

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
      end
   endtask

   task automatic cmd(input logic [7:0] code, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic read_chk(input logic [7:0] expv, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h70;
      #1 check(rd_data == expv, req, rd_data, expv);
      @(negedge clk);
      cmd_valid = 1'b0;
      #1 check(rd_data == 8'h00, "R2 idle read", rd_data, 0);
   endtask

   // acts as the far-end device for one configuration
   task automatic run_cfg(input logic [7:0] c);
      int st, w, dv, pos, halves, since, k;
      logic pb, plr, left_lvl, rgt, e;
      logic [23:0] wl, wr, wd, msk;
      string rq;
      st = c[5] ? 1 : (c[4:3] == 2'b00 ? 0 : (c[4:3] == 2'b01 ? 8 : (c[4:3] == 2'b10 ? 12 : 16)));
      w  = (c[5] || !c[4]) ? 24 : (c[3] ? 16 : 20);
      dv = (c[7:6] == 2'b01) ? 6 : 8;
      rq = c[5] ? "R6 sdout bit" : "R5 sdout bit";
      left_lvl = ~c[5];
      wl = 24'h9A5C31 ^ {3{c}};
      wr = ~wl ^ 24'h00F00F;
      tx_left = wl; tx_right = wr;
      rst_sys_n = 1'b0;
      cmd(8'h60, c);
      @(negedge clk);
      rst_sys_n = 1'b1;
      pb = bclk; plr = lrclk; halves = 0; since = 0; pos = 0;
      while (halves < 5) begin
         @(negedge clk);
         since++;
         if (since > 3 * dv) begin
            check(1'b0, "R3 bit clock stalled", since, dv);
            break;
         end
         if (pb && !bclk) begin
            if (halves > 0) check(since == dv, "R3 bit clock period", since, dv);
            since = 0;
            if (lrclk != plr) begin
               if (halves > 0) check(pos == 31, "R4 slot length", pos + 1, 32);
               else check(lrclk == left_lvl, "R4 left level", lrclk, left_lvl);
               halves++;
               pos = 0;
            end else pos++;
            if (halves > 0 && halves < 5) begin
               rgt = (lrclk != left_lvl);
               wd  = rgt ? wr : wl;
               k   = pos - st;
               e   = (k >= 0 && k < w) ? wd[23-k] : 1'b0;
               check(sdout == e, rq, sdout, e);
               sdin = (k >= 0 && k < w) ? wd[23-k] : 1'b1;
            end
         end
         pb = bclk; plr = lrclk;
      end
      msk = 24'hFFFFFF << (24 - w);
      check(rx_left == (wl & msk), "R7 rx_left", rx_left, wl & msk);
      check(rx_right == (wr & msk), "R7 rx_right", rx_right, wr & msk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [23:0] kl, kr;
      logic        seen_valid;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      read_chk(8'h00, "R2 reset value");
      // R10: halted while in reset
      repeat (20) begin
         @(negedge clk);
         check(!bclk && !sdout, "R10 halted", {bclk, sdout}, 0);
      end
      cmd(8'h60, 8'h01);
      read_chk(8'h00, "R2 bit0 masked");
      cmd(8'h60, 8'h03);
      read_chk(8'h02, "R2 stored value");
      cmd(8'h61, 8'h80);
      read_chk(8'h02, "R1 wrong code ignored");

      for (int r = 0; r < 3; r++)
         for (int d = 0; d < 2; d++)
            for (int f = 0; f < 4; f++)
               run_cfg({r[1:0], d[0], f[1:0], 3'b000});

      // R7: one rx_valid pulse per frame in running mode
      seen_valid = 1'b0;
      repeat (600) begin
         @(negedge clk);
         if (rx_valid) seen_valid = 1'b1;
      end
      check(seen_valid, "R7 rx_valid pulse", seen_valid, 1);

      // R1: write ignored with rst_sys_n high
      cmd(8'h60, 8'h26);
      read_chk(8'hB8, "R1 locked outside reset");

      // R11: transmit words sampled at frame start
      run_cfg(8'h08);

      // R8: parked clocks, justified then I2S
      kl = rx_left; kr = rx_right;
      for (int p = 0; p < 2; p++) begin
         rst_sys_n = 1'b0;
         cmd(8'h60, p ? 8'h24 : 8'h04);
         @(negedge clk);
         rst_sys_n = 1'b1;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            sdin = i[0];
            check(!bclk, "R8 bclk parked", bclk, 0);
            check(lrclk == (p ? 1'b0 : 1'b1), "R8 lrclk parked", lrclk, p ? 0 : 1);
            check(!sdout, "R8 sdout parked", sdout, 0);
         end
         check(rx_left == kl && rx_right == kr, "R8 rx unchanged", rx_left, kl);
      end

      // R9: gated master clock copy
      rst_sys_n = 1'b0;
      cmd(8'h60, 8'h00);
      @(posedge clk); #2 check(clk_out == 1'b1, "R9 clk_out high phase", clk_out, 1);
      @(negedge clk); #1 check(clk_out == 1'b0, "R9 clk_out low phase", clk_out, 0);
      cmd(8'h60, 8'h02);
      @(posedge clk); #2 check(clk_out == 1'b0, "R9 clk_out gated", clk_out, 0);
      repeat (3) @(posedge clk);
      #2 check(clk_out == 1'b0, "R9 clk_out stays gated", clk_out, 0);
      cmd(8'h60, 8'h00);
      @(posedge clk); #2 check(clk_out == 1'b1, "R9 clk_out restored", clk_out, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule